// File: doc/BRIEF.md
# Branch Target and Link Unit

This block resolves the branch-class operations of a compact 16-bit instruction encoding for one execute slot. For each operation it works out the next program counter, whether the link register must be written and with what value, the instruction-state bit that applies afterwards, and whether the fetch pipeline must be flushed. The decoder supplies an operation kind, the offsets it extracted, a condition code and the exchange operand. The register file supplies the PC (address of the current operation plus 4), the link register and the NZCV flags.

Four operations are handled: a conditional branch, an unconditional branch, a branch that exchanges instruction state from bit 0 of a register operand, and a call that spans two halfwords. The first halfword of the call leaves a partial target in the link register. The second halfword adds its low offset to that value, jumps there and stores the return address. Because the partial target waits in the architectural link register, an interrupt taken between the two halves does not lose it. Each result is registered, so it appears one clock after the operation is presented.

Top module: `bxl_unit`

## Requirements
- R1: While `rst` is high at a clock edge, every output is zero on the following cycle.
- R2: Condition codes use the standard 4-bit encoding against N=`in_nzcv[3]`, Z=`[2]`, C=`[1]`, V=`[0]`. The codes are 0 EQ (Z), 1 NE, 2 CS (C), 3 CC, 4 MI (N), 5 PL, 6 VS (V), 7 VC, 8 HI (C and not Z), 9 LS, 10 GE (N==V), 11 LT, 12 GT (not Z and N==V) and 13 LE. Code 15 never passes.
- R3: A taken conditional branch (kind 0) or an unconditional branch (kind 1) produces `o_pc` = `in_pc` + sign-extended `in_ofs`, with `o_pc_we`=1, `o_flush`=1 and `o_lr_we`=0.
- R4: A conditional branch whose condition fails produces `o_pc`=`in_pc`, with `o_pc_we`=0, `o_flush`=0 and `o_lr_we`=0.
- R5: A conditional branch with code 14 raises `o_undef` and writes nothing: `o_pc_we`, `o_flush` and `o_lr_we` are all 0. Every other case leaves `o_undef` at 0.
- R6: First call half (kind 3): `o_lr` = `in_pc` + sign-extend(`in_lofs`·2^12, 23 bits), with `o_lr_we`=1, `o_pc_we`=0 and `o_flush`=0.
- R7: Second call half (kind 4): `o_pc` = `in_lr` + `in_lofs`·2, and `o_lr` = (`in_pc` − 2) with bit 0 set. `o_pc_we`, `o_lr_we` and `o_flush` are all 1.
- R8: Exchange (kind 2): `o_state` = bit 0 of the operand (1 = 16-bit state). `o_pc` is the operand with bit 0 cleared, and with bit 1 also cleared when the new state is 0. `o_pc_we`=1, `o_flush`=1 and `o_lr_we`=0.
- R9: When `in_xop_is_pc` is 1, operand bit 0 is taken as 0 before use, so the exchange selects state 0.
- R10: Results appear exactly one clock after `in_valid`. An idle cycle gives all-zero outputs. Kinds 5 to 7 give `o_valid`=1, `o_pc`=`in_pc` and no writes. All kinds except exchange pass `in_state` to `o_state`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| in_kind | input | 3 | 0 cond, 1 uncond, 2 exchange, 3 call first half, 4 call second half |
| in_cond | input | 4 | Condition code for kind 0 |
| in_ofs | input | OFS_W | Signed byte offset for kinds 0 and 1 |
| in_lofs | input | LOFS_W | 11-bit call offset field |
| in_nzcv | input | 4 | Current flags N,Z,C,V |
| in_pc | input | XLEN | PC (current operation + 4) |
| in_lr | input | XLEN | Current link register |
| in_xop | input | XLEN | Exchange operand |
| in_xop_is_pc | input | 1 | Exchange operand register is the PC |
| in_state | input | 1 | Current instruction state |
| o_valid | output | 1 | Result valid |
| o_pc_we | output | 1 | PC write |
| o_pc | output | XLEN | Next PC |
| o_flush | output | 1 | Flush request |
| o_lr_we | output | 1 | Link register write |
| o_lr | output | XLEN | Link register value |
| o_state | output | 1 | Resulting instruction state |
| o_undef | output | 1 | Undefined condition code |

## Verification
A wrong condition decode shows on the port one cycle later as a flipped `o_flush` and `o_pc_we`, or as `o_pc` staying at `in_pc`. A wrong sign extension or shift in either call half shows as a link or target value that is off by a power of two. Because the first-half link value is fed back as `in_lr` to the second half, an error in the first half also corrupts the jump target one operation later. The exchange alignment mask and the forced-zero rule for a PC operand show directly in the low two bits of `o_pc` and in `o_state` in the cycle after the operation.

// File: rtl/bxl_pkg.sv
package bxl_pkg;
  typedef enum logic [2:0] {
    BK_COND   = 3'd0,
    BK_UNCOND = 3'd1,
    BK_EXCH   = 3'd2,
    BK_CALL1  = 3'd3,
    BK_CALL2  = 3'd4
  } br_kind_e;

  localparam logic [3:0] CC_UNDEF = 4'hE;
endpackage

// File: rtl/bxl_cond_eval.sv
module bxl_cond_eval (
  input  logic [3:0] cond,
  input  logic [3:0] nzcv,
  output logic       pass,
  output logic       undef
);
  logic n, z, c, v;
  assign n = nzcv[3];
  assign z = nzcv[2];
  assign c = nzcv[1];
  assign v = nzcv[0];

  always_comb begin
    undef = 1'b0;
    case (cond)
      4'h0: pass = z;
      4'h1: pass = !z;
      4'h2: pass = c;
      4'h3: pass = !c;
      4'h4: pass = n;
      4'h5: pass = !n;
      4'h6: pass = v;
      4'h7: pass = !v;
      4'h8: pass = c && !z;
      4'h9: pass = !c || z;
      4'hA: pass = (n == v);
      4'hB: pass = (n != v);
      4'hC: pass = !z && (n == v);
      4'hD: pass = z || (n != v);
      4'hE: begin pass = 1'b0; undef = 1'b1; end
      default: pass = 1'b0;
    endcase
  end

  always_comb begin
    assert_undef_not_taken_R5: assert (!(undef && pass));
  end
endmodule

// File: rtl/bxl_call_link.sv
module bxl_call_link #(
  parameter int XLEN   = 32,
  parameter int LOFS_W = 11
) (
  input  logic [LOFS_W-1:0] lofs,
  input  logic [XLEN-1:0]   pc,
  input  logic [XLEN-1:0]   lr,
  output logic [XLEN-1:0]   first_lr,
  output logic [XLEN-1:0]   second_pc,
  output logic [XLEN-1:0]   second_lr
);
  localparam int HI_SH = LOFS_W + 1;
  localparam int HI_W  = LOFS_W + HI_SH;

  logic [XLEN-1:0] hi_ext, lo_ext;
  assign hi_ext = {{(XLEN-HI_W){lofs[LOFS_W-1]}}, lofs, {HI_SH{1'b0}}};
  assign lo_ext = {{(XLEN-LOFS_W-1){1'b0}}, lofs, 1'b0};

  assign first_lr  = pc + hi_ext;
  assign second_pc = lr + lo_ext;
  assign second_lr = (pc - XLEN'(2)) | XLEN'(1);
endmodule

// File: rtl/bxl_exchange.sv
module bxl_exchange #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] xop,
  input  logic            xop_is_pc,
  output logic [XLEN-1:0] tgt,
  output logic            state
);
  logic [XLEN-1:0] op;
  always_comb begin
    op = xop;
    if (xop_is_pc) op[0] = 1'b0;
  end

  assign state = op[0];
  assign tgt   = {op[XLEN-1:2], op[1] & op[0], 1'b0};
endmodule

// File: rtl/bxl_unit.sv
module bxl_unit
  import bxl_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int OFS_W  = 12,
  parameter int LOFS_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        in_kind,
  input  logic [3:0]        in_cond,
  input  logic [OFS_W-1:0]  in_ofs,
  input  logic [LOFS_W-1:0] in_lofs,
  input  logic [3:0]        in_nzcv,
  input  logic [XLEN-1:0]   in_pc,
  input  logic [XLEN-1:0]   in_lr,
  input  logic [XLEN-1:0]   in_xop,
  input  logic              in_xop_is_pc,
  input  logic              in_state,
  output logic              o_valid,
  output logic              o_pc_we,
  output logic [XLEN-1:0]   o_pc,
  output logic              o_flush,
  output logic              o_lr_we,
  output logic [XLEN-1:0]   o_lr,
  output logic              o_state,
  output logic              o_undef
);
  logic            c_pass, c_undef;
  logic [XLEN-1:0] k_first_lr, k_second_pc, k_second_lr;
  logic [XLEN-1:0] x_tgt;
  logic            x_state;
  logic [XLEN-1:0] rel_tgt;

  bxl_cond_eval u_cond (
    .cond (in_cond),
    .nzcv (in_nzcv),
    .pass (c_pass),
    .undef(c_undef)
  );

  bxl_call_link #(.XLEN(XLEN), .LOFS_W(LOFS_W)) u_call (
    .lofs     (in_lofs),
    .pc       (in_pc),
    .lr       (in_lr),
    .first_lr (k_first_lr),
    .second_pc(k_second_pc),
    .second_lr(k_second_lr)
  );

  bxl_exchange #(.XLEN(XLEN)) u_exch (
    .xop      (in_xop),
    .xop_is_pc(in_xop_is_pc),
    .tgt      (x_tgt),
    .state    (x_state)
  );

  assign rel_tgt = in_pc + {{(XLEN-OFS_W){in_ofs[OFS_W-1]}}, in_ofs};

  logic            n_valid, n_pc_we, n_flush, n_lr_we, n_state, n_undef;
  logic [XLEN-1:0] n_pc, n_lr;

  always_comb begin
    n_valid = 1'b0; n_pc_we = 1'b0; n_flush = 1'b0; n_lr_we = 1'b0;
    n_state = 1'b0; n_undef = 1'b0; n_pc = '0; n_lr = '0;
    if (in_valid) begin
      n_valid = 1'b1;
      n_pc    = in_pc;
      n_state = in_state;
      case (in_kind)
        BK_COND: begin
          n_undef = c_undef;
          if (c_pass) begin
            n_pc = rel_tgt; n_pc_we = 1'b1; n_flush = 1'b1;
          end
        end
        BK_UNCOND: begin
          n_pc = rel_tgt; n_pc_we = 1'b1; n_flush = 1'b1;
        end
        BK_EXCH: begin
          n_pc = x_tgt; n_state = x_state; n_pc_we = 1'b1; n_flush = 1'b1;
        end
        BK_CALL1: begin
          n_lr = k_first_lr; n_lr_we = 1'b1;
        end
        BK_CALL2: begin
          n_pc = k_second_pc; n_lr = k_second_lr;
          n_pc_we = 1'b1; n_lr_we = 1'b1; n_flush = 1'b1;
        end
        default: ;
      endcase
    end
  end

  logic [2:0] kind_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid <= 1'b0; o_pc_we <= 1'b0; o_pc <= '0; o_flush <= 1'b0;
      o_lr_we <= 1'b0; o_lr <= '0; o_state <= 1'b0; o_undef <= 1'b0;
      kind_q  <= 3'd7;
    end else begin
      o_valid <= n_valid; o_pc_we <= n_pc_we; o_pc <= n_pc; o_flush <= n_flush;
      o_lr_we <= n_lr_we; o_lr <= n_lr; o_state <= n_state; o_undef <= n_undef;
      kind_q  <= in_valid ? in_kind : 3'd7;
    end
  end

  assert_undef_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    o_undef |-> (!o_flush && !o_pc_we && !o_lr_we));
  assert_call1_no_jump_R6: assert property (@(posedge clk) disable iff (rst)
    (o_valid && kind_q == BK_CALL1) |-> (o_lr_we && !o_flush && !o_pc_we));
  assert_call2_jump_R7: assert property (@(posedge clk) disable iff (rst)
    (o_valid && kind_q == BK_CALL2) |-> (o_lr_we && o_flush && o_lr[0]));
  assert_exch_align_R8: assert property (@(posedge clk) disable iff (rst)
    (o_valid && kind_q == BK_EXCH) |-> (!o_pc[0] && (o_state || !o_pc[1]) && !o_lr_we));
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !o_valid |-> (!o_flush && !o_pc_we && !o_lr_we && !o_undef));
  assert_flush_writes_pc_R3: assert property (@(posedge clk) disable iff (rst)
    o_flush |-> o_pc_we);
endmodule

// File: tb/sim_bxl_unit.sv
module sim_bxl_unit;
  localparam int XLEN = 32;
  localparam int OFS_W = 12;
  localparam int LOFS_W = 11;

  logic clk = 1'b0;
  logic rst;
  logic in_valid, in_xop_is_pc, in_state;
  logic [2:0] in_kind;
  logic [3:0] in_cond, in_nzcv;
  logic [OFS_W-1:0] in_ofs;
  logic [LOFS_W-1:0] in_lofs;
  logic [XLEN-1:0] in_pc, in_lr, in_xop;
  logic o_valid, o_pc_we, o_flush, o_lr_we, o_state, o_undef;
  logic [XLEN-1:0] o_pc, o_lr;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  bxl_unit #(.XLEN(XLEN), .OFS_W(OFS_W), .LOFS_W(LOFS_W)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_kind(in_kind),
    .in_cond(in_cond), .in_ofs(in_ofs), .in_lofs(in_lofs), .in_nzcv(in_nzcv),
    .in_pc(in_pc), .in_lr(in_lr), .in_xop(in_xop), .in_xop_is_pc(in_xop_is_pc),
    .in_state(in_state), .o_valid(o_valid), .o_pc_we(o_pc_we), .o_pc(o_pc),
    .o_flush(o_flush), .o_lr_we(o_lr_we), .o_lr(o_lr), .o_state(o_state),
    .o_undef(o_undef));

  function automatic bit ref_cond(input logic [3:0] c, input logic [3:0] f);
    bit n, z, cy, v;
    n = f[3]; z = f[2]; cy = f[1]; v = f[0];
    case (c)
      4'h0: return z;        4'h1: return !z;
      4'h2: return cy;       4'h3: return !cy;
      4'h4: return n;        4'h5: return !n;
      4'h6: return v;        4'h7: return !v;
      4'h8: return cy && !z; 4'h9: return !cy || z;
      4'hA: return n == v;   4'hB: return n != v;
      4'hC: return !z && (n == v);
      4'hD: return z || (n != v);
      default: return 1'b0;
    endcase
  endfunction

  // packed expectation: valid,pc_we,flush,lr_we,state,undef,pc,lr
  function automatic logic [6+2*XLEN-1:0] ref_out();
    logic v, pwe, fl, lwe, st, ud;
    logic [XLEN-1:0] pc, lr, op;
    v = 0; pwe = 0; fl = 0; lwe = 0; st = 0; ud = 0; pc = '0; lr = '0;
    if (in_valid) begin
      v = 1; pc = in_pc; st = in_state;
      case (in_kind)
        3'd0: begin
          ud = (in_cond == 4'hE);
          if (ref_cond(in_cond, in_nzcv)) begin
            pc = in_pc + XLEN'($signed(in_ofs)); pwe = 1; fl = 1;
          end
        end
        3'd1: begin pc = in_pc + XLEN'($signed(in_ofs)); pwe = 1; fl = 1; end
        3'd2: begin
          op = in_xop;
          if (in_xop_is_pc) op[0] = 0;
          st = op[0];
          pc = op & ~XLEN'(1);
          if (!st) pc = pc & ~XLEN'(2);
          pwe = 1; fl = 1;
        end
        3'd3: begin
          lr = in_pc + XLEN'($signed({in_lofs, 12'b0}));
          lwe = 1;
        end
        3'd4: begin
          pc = in_lr + (XLEN'(in_lofs) << 1);
          lr = (in_pc - 2) | 1;
          pwe = 1; lwe = 1; fl = 1;
        end
        default: ;
      endcase
    end
    return {v, pwe, fl, lwe, st, ud, pc, lr};
  endfunction

  task automatic check(input string req, input logic [6+2*XLEN-1:0] exp);
    logic [6+2*XLEN-1:0] act;
    act = {o_valid, o_pc_we, o_flush, o_lr_we, o_state, o_undef, o_pc, o_lr};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual flags=%b pc=%h lr=%h expected flags=%b pc=%h lr=%h",
        req, act[6+2*XLEN-1:2*XLEN], act[2*XLEN-1:XLEN], act[XLEN-1:0],
        exp[6+2*XLEN-1:2*XLEN], exp[2*XLEN-1:XLEN], exp[XLEN-1:0]);
    end
  endtask

  task automatic apply(input string req);
    logic [6+2*XLEN-1:0] exp;
    exp = ref_out();
    @(posedge clk);
    #1;
    check(req, exp);
    @(negedge clk);
  endtask

  task automatic set_op(input logic [2:0] k, input logic [3:0] c, input logic [3:0] f,
                        input logic [OFS_W-1:0] o, input logic [LOFS_W-1:0] lo,
                        input logic [XLEN-1:0] pc, input logic [XLEN-1:0] lr,
                        input logic [XLEN-1:0] x, input logic xp, input logic st);
    in_valid = 1; in_kind = k; in_cond = c; in_nzcv = f; in_ofs = o; in_lofs = lo;
    in_pc = pc; in_lr = lr; in_xop = x; in_xop_is_pc = xp; in_state = st;
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [XLEN-1:0] saved_lr;
    void'($urandom(32'd1234));
    rst = 1;
    set_op(3'd1, 4'h0, 4'h0, 12'h010, 11'h0, 32'h100, 32'h0, 32'h0, 0, 1);
    @(negedge clk);
    @(posedge clk); #1;
    check("R1 reset", '0);
    @(negedge clk);
    rst = 0;

    // R2/R3/R4 directed: EQ taken, NE not taken, GT, LE
    set_op(3'd0, 4'h0, 4'b0100, 12'hFF0, 11'h0, 32'h0000_2000, 0, 0, 0, 1); apply("R2 R3 EQ taken backward");
    set_op(3'd0, 4'h1, 4'b0100, 12'h040, 11'h0, 32'h0000_2000, 0, 0, 0, 1); apply("R4 NE not taken");
    set_op(3'd0, 4'hC, 4'b1001, 12'h7FE, 11'h0, 32'h0000_3000, 0, 0, 0, 1); apply("R2 GT N==V");
    set_op(3'd0, 4'hD, 4'b1000, 12'h800, 11'h0, 32'h0000_3000, 0, 0, 0, 1); apply("R2 LE N!=V");
    // R5: undefined code and code 15
    set_op(3'd0, 4'hE, 4'b1111, 12'h020, 11'h0, 32'h0000_4000, 0, 0, 0, 1); apply("R5 code 14 undefined");
    set_op(3'd0, 4'hF, 4'b0000, 12'h020, 11'h0, 32'h0000_4000, 0, 0, 0, 1); apply("R2 R5 code 15 never");
    // R8 / R9 exchange
    set_op(3'd2, 4'h0, 4'h0, 0, 0, 32'h0000_5000, 0, 32'h0800_0003, 0, 1); apply("R8 exchange to 16-bit");
    set_op(3'd2, 4'h0, 4'h0, 0, 0, 32'h0000_5000, 0, 32'h0800_0006, 0, 1); apply("R8 exchange to 32-bit clears bit1");
    set_op(3'd2, 4'h0, 4'h0, 0, 0, 32'h0000_5007, 0, 32'h0000_5007, 1, 1); apply("R9 PC operand bit0 forced");
    // R6/R7 call pair, negative offset, link fed back
    set_op(3'd3, 4'h0, 4'h0, 0, 11'h7FF, 32'h0001_0004, 32'h0, 0, 0, 1);
    apply("R6 first half negative");
    saved_lr = o_lr;
    if (saved_lr !== 32'h0001_0004 - 32'h1000) begin
      n_chk++; n_bad++;
      $display("FAIL R6 link value: actual %h expected %h", saved_lr, 32'h0000_F004);
    end else n_chk++;
    set_op(3'd4, 4'h0, 4'h0, 0, 11'h123, 32'h0001_0006, saved_lr, 0, 0, 1);
    apply("R7 second half from link");
    set_op(3'd3, 4'h0, 4'h0, 0, 11'h3FF, 32'h0000_0004, 32'h0, 0, 0, 1); apply("R6 first half max positive");
    // R10 idle and unused kinds
    in_valid = 0; apply("R10 idle");
    set_op(3'd6, 4'h0, 4'h0, 12'h010, 11'h5, 32'h0000_7000, 32'h9, 32'h3, 0, 1); apply("R10 unused kind");

    for (int i = 0; i < 3000; i++) begin
      logic [2:0] k;
      k = 3'($urandom_range(0, 4));
      set_op(k, 4'($urandom), 4'($urandom), 12'($urandom), 11'($urandom),
             $urandom & 32'hFFFF_FFFE, $urandom, $urandom, 1'($urandom_range(0, 7) == 0),
             1'($urandom));
      in_valid = ($urandom_range(0, 9) != 0);
      case (k)
        3'd0: apply("R2 R3 R4 R5 random cond");
        3'd1: apply("R3 random uncond");
        3'd2: apply("R8 R9 random exchange");
        3'd3: apply("R6 random first half");
        default: apply("R7 random second half");
      endcase
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule